// File: doc/BRIEF.md
# Time-Match Alarm and Status Unit

This unit watches the running calendar fields of a real-time clock and raises an alarm when they reach a programmed moment. A bank of threshold registers holds one target value per time field. A configuration register selects which fields must match, and a separate override bit makes the alarm fire on every second whatever the compare settings are. The alarm is evaluated once per seconds tick. It latches into bit 4 of a status byte and drives an active-low alarm pin.

Software clears the alarm by accessing the alarm registers. Any read or write of the configuration register or of a threshold register drops the latch. The status byte also carries three externally sourced condition bits: battery low, data valid and crystal failure. Its low nibble is always zero.

Field `g` of `time_in` occupies bits `[g*FW +: FW]`. Register addresses are as follows: threshold `g` at address `g`, the configuration register at address `NFIELD`, and the status byte at address `NFIELD+1`. Every other address reads zero.

Top module: `tmatch_alarm`

## Requirements
- R1: After reset the configuration and all threshold registers read 00h, `alarm_n` is 1 and status bit 4 is 0.
- R2: With configuration bit 7 set, every `sec_tick` raises the alarm, whatever the other configuration bits and the thresholds hold.
- R3: A raised alarm sets status bit 4 to 1 and drives `alarm_n` low in the cycle after the triggering tick. It stays that way until cleared.
- R4: A read or write strobe whose address is a threshold register or the configuration register clears the alarm: `alarm_n` returns to 1 and status bit 4 to 0 after that edge.
- R5: With bit 7 clear, configuration bit 0 (value 01h) raises the alarm on a tick where field 0 (seconds) equals threshold 0.
- R6: With bit 7 clear, configuration bit 1 (value 02h) raises the alarm on a tick where field 1 (minutes) equals threshold 1.
- R7: When several compare bits (bit g for field g, g < NFIELD) are set, the alarm needs every enabled field to match on the same tick.
- R8: With bit 7 clear and all compare bits clear, the alarm never fires.
- R9: The compare is sampled only on `sec_tick`. A match held between ticks does not raise the alarm.
- R10: When a clearing access and a trigger fall in the same cycle, the alarm ends up raised.
- R11: Status bits 3:0 read 0. Bit 5 follows `batt_low`, bit 6 follows `data_valid` and bit 7 follows `xtal_fail`.
- R12: Accesses to the status address or to unmapped addresses leave the alarm untouched.
- R13: Written values of the threshold and configuration registers read back unchanged on `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| time_in | input | NFIELD*FW | Current time fields, seconds in field 0 |
| reg_addr | input | AW | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| batt_low | input | 1 | Battery-low condition |
| data_valid | input | 1 | Data-valid condition |
| xtal_fail | input | 1 | Crystal-failure condition |
| status | output | 8 | Status byte |
| alarm_n | output | 1 | Active-low alarm |

## Verification
The bench builds the unit with the default parameters: seven 8-bit fields and a 4-bit address. This gives every compare-enable bit a field, so the override bit sits directly above the enables. It also places the status address next to the configuration address, so the boundary between clearing and non-clearing addresses is exercised at adjacent values. The scenarios drive ticks with matching, mismatching and held fields. Clearing accesses land both alone and on a tick edge.

// File: rtl/tmatch_alarm.sv
module tmatch_alarm #(
  parameter int NFIELD = 7,
  parameter int FW     = 8,
  parameter int AW     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_tick,
  input  logic [NFIELD*FW-1:0] time_in,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic                 batt_low,
  input  logic                 data_valid,
  input  logic                 xtal_fail,
  output logic [7:0]           status,
  output logic                 alarm_n
);
  localparam logic [AW-1:0] CFG_A  = AW'(NFIELD);
  localparam logic [AW-1:0] STAT_A = AW'(NFIELD + 1);

  logic [7:0]        cfg_q;
  logic [FW-1:0]     thr_q [NFIELD];
  logic [NFIELD-1:0] fld_eq;
  logic              alarm_q;

  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    assign fld_eq[g] = time_in[g*FW +: FW] == thr_q[g];
  end

  wire [NFIELD-1:0] cmp_en = cfg_q[NFIELD-1:0];
  wire cmp_hit = (|cmp_en) & (&(fld_eq | ~cmp_en));
  wire fire    = sec_tick & (cfg_q[7] | cmp_hit);
  wire acc_clr = (reg_rd | reg_wr) & (reg_addr <= CFG_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      alarm_q <= 1'b0;
      for (int i = 0; i < NFIELD; i++) thr_q[i] <= '0;
    end else begin
      if (reg_wr && reg_addr == CFG_A) cfg_q <= reg_wdata;
      for (int i = 0; i < NFIELD; i++)
        if (reg_wr && reg_addr == AW'(i)) thr_q[i] <= FW'(reg_wdata);
      if (fire)         alarm_q <= 1'b1;
      else if (acc_clr) alarm_q <= 1'b0;
    end
  end

  assign status  = {xtal_fail, data_valid, batt_low, alarm_q, 4'b0000};
  assign alarm_n = ~alarm_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CFG_A)       reg_rdata = cfg_q;
    else if (reg_addr == STAT_A) reg_rdata = status;
    else
      for (int i = 0; i < NFIELD; i++)
        if (reg_addr == AW'(i)) reg_rdata = 8'(thr_q[i]);
  end
endmodule

module tmatch_alarm_chk #(
  parameter int NFIELD = 7,
  parameter int AW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_tick,
  input logic [AW-1:0] reg_addr,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [7:0]    cfg,
  input logic [7:0]    status,
  input logic          alarm_n
);
  assert_pin_matches_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_n == !status[4]);
  assert_low_nibble_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:0] == 4'b0000);
  assert_override_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && cfg[7]) |=> !alarm_n);
  assert_access_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd || reg_wr) && reg_addr <= AW'(NFIELD) && !sec_tick) |=> alarm_n);
  assert_only_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && alarm_n) |=> alarm_n);
  assert_no_enable_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 8'h00 && alarm_n) |=> alarm_n);
endmodule

bind tmatch_alarm tmatch_alarm_chk #(.NFIELD(NFIELD), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .cfg(cfg_q), .status(status),
  .alarm_n(alarm_n)
);

// File: tb/tmatch_alarm_tb.sv
module tmatch_alarm_tb_top;
  localparam int NF = 7, FW = 8, AW = 4;
  localparam logic [AW-1:0] CFG_A = AW'(NF), STAT_A = AW'(NF + 1);

  logic clk = 0, rst_n = 0, sec_tick = 0, reg_rd = 0, reg_wr = 0;
  logic batt_low = 0, data_valid = 0, xtal_fail = 0;
  logic [NF*FW-1:0] time_in = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, status;
  logic alarm_n;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  tmatch_alarm #(.NFIELD(NF), .FW(FW), .AW(AW)) dut_i (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic fld(int i, logic [7:0] v);
    time_in[i*FW +: FW] = v;
  endtask

  task automatic clear_alarm();
    logic [7:0] d;
    rd(CFG_A, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 alarm_n", {7'd0, alarm_n}, 8'h01);
    chk("R1 status", status, 8'h00);
    rd(CFG_A, d); chk("R1 cfg", d, 8'h00);
    for (int i = 0; i < NF; i++) begin rd(AW'(i), d); chk("R1 thr", d, 8'h00); end
  endtask

  task automatic t_status();
    batt_low = 1; data_valid = 1; #1;
    chk("R11 batt+valid", status, 8'h60);
    batt_low = 0; xtal_fail = 1; #1;
    chk("R11 xtal+valid", status, 8'hC0);
    xtal_fail = 0; data_valid = 0; #1;
    chk("R11 none", status, 8'h00);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(2, 8'h5A); rd(2, d); chk("R13 thr2", d, 8'h5A);
    wr(CFG_A, 8'h40); rd(CFG_A, d); chk("R13 cfg", d, 8'h40);
    rd(AW'(NF + 3), d); chk("R13 unmapped", d, 8'h00);
    wr(2, 8'h00); wr(CFG_A, 8'h00);
  endtask

  task automatic t_no_enable();
    tick(); chk("R8 idle", {7'd0, alarm_n}, 8'h01);
  endtask

  task automatic t_seconds();
    wr(0, 8'h30); wr(CFG_A, 8'h01);
    fld(0, 8'h29); tick(); chk("R5 mismatch", {7'd0, alarm_n}, 8'h01);
    fld(0, 8'h30); tick(); chk("R5 match pin", {7'd0, alarm_n}, 8'h00);
    chk("R3 status bit", status, 8'h10);
    repeat (3) @(negedge clk);
    chk("R3 latched", {7'd0, alarm_n}, 8'h00);
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    rd(STAT_A, d); chk("R12 status read value", d, 8'h10);
    wr(STAT_A, 8'hFF); wr(AW'(NF + 4), 8'h00);
    chk("R12 kept", {7'd0, alarm_n}, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    rd(CFG_A, d); chk("R4 read cfg clears", {7'd0, alarm_n}, 8'h01);
    chk("R4 status", status, 8'h00);
    tick(); chk("R4 refire", {7'd0, alarm_n}, 8'h00);
    wr(5, 8'h00); chk("R4 write thr clears", {7'd0, alarm_n}, 8'h01);
  endtask

  task automatic t_tick_only();
    repeat (6) @(negedge clk);
    chk("R9 held match no tick", {7'd0, alarm_n}, 8'h01);
    tick(); chk("R9 tick fires", {7'd0, alarm_n}, 8'h00);
    clear_alarm();
    repeat (4) @(negedge clk);
    chk("R9 no refire", {7'd0, alarm_n}, 8'h01);
  endtask

  task automatic t_minutes();
    wr(1, 8'h15); wr(CFG_A, 8'h02);
    fld(0, 8'h07); fld(1, 8'h14); tick();
    chk("R6 mismatch", {7'd0, alarm_n}, 8'h01);
    fld(1, 8'h15); tick(); chk("R6 match", {7'd0, alarm_n}, 8'h00);
    clear_alarm();
  endtask

  task automatic t_and();
    wr(CFG_A, 8'h03);
    fld(0, 8'h30); fld(1, 8'h16); tick();
    chk("R7 one of two", {7'd0, alarm_n}, 8'h01);
    fld(1, 8'h15); tick(); chk("R7 both", {7'd0, alarm_n}, 8'h00);
    clear_alarm();
  endtask

  task automatic t_override();
    fld(0, 8'h01); fld(1, 8'h02);
    wr(CFG_A, 8'h80); tick(); chk("R2 override", {7'd0, alarm_n}, 8'h00);
    clear_alarm(); tick(); chk("R2 again", {7'd0, alarm_n}, 8'h00);
    wr(CFG_A, 8'h83); tick(); chk("R2 ignores compare", {7'd0, alarm_n}, 8'h00);
    clear_alarm();
  endtask

  task automatic t_priority();
    wr(CFG_A, 8'h80);
    @(negedge clk); sec_tick = 1; reg_rd = 1; reg_addr = CFG_A;
    @(negedge clk); sec_tick = 0; reg_rd = 0;
    chk("R10 trigger wins", {7'd0, alarm_n}, 8'h00);
    wr(CFG_A, 8'h00);
    chk("R10 later clear", {7'd0, alarm_n}, 8'h01);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_status();
    t_readback();
    t_no_enable();
    t_seconds();
    t_other_addr();
    t_clear();
    wr(CFG_A, 8'h01);
    t_tick_only();
    t_minutes();
    t_and();
    t_override();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule